// File: doc/BRIEF.md
# EDO DRAM Strobe Decoder

This block is a synthesizable behavioural stand-in for an EDO DRAM with a 16-bit word, for use when testing DRAM controllers. It samples the row strobe, two byte-lane column strobes, the write strobe and the output enable on a system clock. It latches the multiplexed row and column addresses from one shared address bus. It then sorts each row-strobe cycle into one of six kinds: standby, read, early write, read-modify-write, row-strobe-only refresh, or refresh with the column strobe ahead of the row strobe.

Every reaction shows one clock after the sampled input edge that causes it. An exception is the output enable: `oeN` gates the lane drive at once. The storage is a small array indexed by the low bits of the row and column addresses, so rows and columns alias. A 9-bit internal counter supplies the row for strobe-order refreshes. A per-row age tracker raises a sticky error flag when a tracked row goes too long without being opened or refreshed.

Read data follows the extended-data-out rule. It stays on the pins after a column strobe rises inside a row cycle, and is only replaced at the next column-strobe fall.

Top module: `edoStrobeDecoder`

## Requirements
- R1: After reset, and whenever `rasN`, `casLoN` and `casHiN` are all high, both `dOutEn` bits are 0 and, one clock after `rasN` is sampled high, `cycleKind` is 0 (standby); `refreshErr` is 0 after reset. Kind codes: 0 standby, 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 strobe-order refresh.
- R2: A sampled fall of `rasN` while both column strobes are high latches `addr` as the row, sets `cycleKind` to 4, leaves both lanes undriven and counts as a refresh of that row.
- R3: Within an open row cycle, a fall of a column strobe with `weN` low writes that lane (lane 0 is bits 7:0 under `casLoN`, lane 1 is bits 15:8 under `casHiN`) at the latched row and the column taken from `addr` at that fall. `cycleKind` becomes 2 and the lane stays undriven whatever `oeN` is.
- R4: A column-strobe fall with `weN` high loads that lane's stored byte onto `dOut` and sets `cycleKind` to 1. The lane is driven while `oeN` is low and undriven while it is high. It is released once `rasN` and that lane's column strobe are both high, whichever rises last.
- R5: Inside a row cycle, a column strobe rising keeps the lane's data and drive. A new column presented meanwhile takes effect only at the next fall of that strobe.
- R6: When `weN` falls while a lane's column strobe is still low after a read in that strobe period, `dIn` is written to that lane and `cycleKind` becomes 3. `dOut` keeps the old data that was read.
- R7: A fall of `rasN` while either column strobe is low sets `cycleKind` to 5, refreshes the row given by the internal 9-bit counter and advances the counter by one (wrapping). No data is accessed.
- R8: Storage holds 2^ROW_BITS rows by 2^COL_BITS columns, indexed by the low address bits, so row addresses that differ only above bit ROW_BITS-1 reach the same word.
- R9: If any tracked row goes REF_LIMIT clocks without being opened or refreshed, `refreshErr` goes to 1.
- R10: `refreshErr` stays at 1 until reset, whatever refreshes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casLoN | input | 1 | Column strobe for bits 7:0, active low |
| casHiN | input | 1 | Column strobe for bits 15:8, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dIn | input | DATA_W | Write data |
| dOut | output | DATA_W | Read data held per lane |
| dOutEn | output | 2 | Per-lane drive enable (0 = high impedance) |
| cycleKind | output | 3 | Classification of the current row cycle |
| refreshErr | output | 1 | Sticky row-age violation flag |

## Verification
A vector table walks the decoder through several sequences: early writes on one lane and on both lanes with the output enable low, single-lane and word reads, and toggling of the output enable during a read. It also covers a late write-strobe fall after a read, a column-strobe rise followed by a new column inside the row cycle, a strobe-order refresh, and an aliased row address. Together these separate early write from read-modify-write, OE gating from strobe release, and EDO hold from reload.

Directed runs check the refresh counter without looking inside the block. After a long idle, eight strobe-order refreshes must cover every tracked row, or the age flag would rise. The same check is repeated with row-only refreshes. A final stretch of neglect then shows that the flag is set and stays set until reset.

// File: rtl/edoDecPkg.sv
package edoDecPkg;

  typedef enum logic [2:0] {
    KIND_IDLE   = 3'd0,
    KIND_READ   = 3'd1,
    KIND_WRITE  = 3'd2,
    KIND_RMW    = 3'd3,
    KIND_ROWREF = 3'd4,
    KIND_CBR    = 3'd5
  } cycKind_t;

  // per-lane strobes from control to datapath
  typedef struct packed {
    logic [1:0] rdLane;
    logic [1:0] wrLane;
    logic [1:0] laneOff;
    logic       rowTouch;
  } laneStrobes_t;

endpackage

// File: rtl/edoStrobeCtrl.sv
module edoStrobeCtrl
  import edoDecPkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rasN,
  input  logic [1:0]          casN,
  input  logic                weN,
  input  logic [ADDR_W-1:0]   addr,
  output laneStrobes_t        stb,
  output logic [ROW_BITS-1:0] accRow,
  output logic [COL_BITS-1:0] accCol,
  output logic [ROW_BITS-1:0] touchRow,
  output logic [ADDR_W-1:0]   refCount,
  output logic [2:0]          kindOut
);
  localparam int KEEP_W = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

  logic                rasQ, weQ, rowOpen;
  logic [1:0]          casQ, readSeen;
  logic [ROW_BITS-1:0] rowReg;
  logic [COL_BITS-1:0] colReg;
  logic [ADDR_W-1:0]   refCnt;
  cycKind_t            kindQ, kindD;

  logic       rasFall, weFall, cbrStart, rowStart, pageLive;
  logic [1:0] casFall, earlyWr, rdHit, lateWr;
  logic       unusedAddrHigh;

  assign unusedAddrHigh = ^addr[ADDR_W-1:KEEP_W];

  assign rasFall  = rasQ & ~rasN;
  assign casFall  = casQ & ~casN;
  assign weFall   = weQ & ~weN;
  assign cbrStart = rasFall & (casN != 2'b11);
  assign rowStart = rasFall & (casN == 2'b11);
  assign pageLive = ~rasN & rowOpen;

  assign earlyWr = {2{pageLive & ~weN}} & casFall;
  assign rdHit   = {2{pageLive &  weN}} & casFall;
  assign lateWr  = {2{pageLive & weFall}} & ~casN & readSeen & ~casFall;

  assign stb.rdLane   = rdHit;
  assign stb.wrLane   = earlyWr | lateWr;
  assign stb.laneOff  = ({2{rasN}} & casN) | earlyWr | {2{rasFall}};
  assign stb.rowTouch = rasFall;

  assign accRow   = rowReg;
  assign accCol   = (|casFall) ? addr[COL_BITS-1:0] : colReg;
  assign touchRow = cbrStart ? refCnt[ROW_BITS-1:0] : addr[ROW_BITS-1:0];
  assign refCount = refCnt;
  assign kindOut  = kindQ;

  always_comb begin
    kindD = kindQ;
    if (rasN)              kindD = KIND_IDLE;
    else if (cbrStart)     kindD = KIND_CBR;
    else if (rowStart)     kindD = KIND_ROWREF;
    else if (|earlyWr)     kindD = KIND_WRITE;
    else if (|rdHit)       kindD = KIND_READ;
    else if (|lateWr)      kindD = KIND_RMW;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasQ     <= 1'b1;
      casQ     <= 2'b11;
      weQ      <= 1'b1;
      rowOpen  <= 1'b0;
      readSeen <= 2'b00;
      rowReg   <= '0;
      colReg   <= '0;
      refCnt   <= '0;
      kindQ    <= KIND_IDLE;
    end else begin
      rasQ  <= rasN;
      casQ  <= casN;
      weQ   <= weN;
      kindQ <= kindD;
      if (rasN)          rowOpen <= 1'b0;
      else if (rowStart) rowOpen <= 1'b1;
      if (rowStart) rowReg <= addr[ROW_BITS-1:0];
      if (pageLive && (|casFall)) colReg <= addr[COL_BITS-1:0];
      if (cbrStart) refCnt <= refCnt + 1'b1;
      for (int i = 0; i < 2; i++) begin
        if (casN[i] || rasN) readSeen[i] <= 1'b0;
        else if (rdHit[i])   readSeen[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/edoWordStore.sv
module edoWordStore
  import edoDecPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneStrobes_t        stb,
  input  logic [ROW_BITS-1:0] accRow,
  input  logic [COL_BITS-1:0] accCol,
  input  logic [DATA_W-1:0]   dIn,
  input  logic                oeN,
  output logic [DATA_W-1:0]   dOut,
  output logic [1:0]          dOutEn
);
  localparam int LANE_W = DATA_W / 2;
  localparam int IDX_W  = ROW_BITS + COL_BITS;
  localparam int DEPTH  = 2 ** IDX_W;

  logic [IDX_W-1:0] idx;
  assign idx = {accRow, accCol};

  for (genvar ln = 0; ln < 2; ln++) begin : gLane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] held;
    logic              laneOn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < DEPTH; k++) cells[k] <= '0;
        held   <= '0;
        laneOn <= 1'b0;
      end else begin
        if (stb.wrLane[ln]) cells[idx] <= dIn[ln*LANE_W +: LANE_W];
        if (stb.rdLane[ln]) begin
          held   <= cells[idx];
          laneOn <= 1'b1;
        end else if (stb.laneOff[ln]) begin
          laneOn <= 1'b0;
        end
      end
    end

    assign dOut[ln*LANE_W +: LANE_W] = held;
    assign dOutEn[ln] = laneOn & ~oeN;
  end

endmodule

// File: rtl/edoRowAgeWatch.sv
module edoRowAgeWatch #(
  parameter int ROW_BITS  = 3,
  parameter int REF_LIMIT = 4096
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                touch,
  input  logic [ROW_BITS-1:0] touchRow,
  output logic                refreshErr
);
  localparam int NROWS = 2 ** ROW_BITS;
  localparam int AGE_W = $clog2(REF_LIMIT + 1);

  logic [NROWS-1:0] stale;

  for (genvar r = 0; r < NROWS; r++) begin : gRow
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       age <= '0;
      else if (touch && (touchRow == ROW_BITS'(r)))    age <= '0;
      else if (age != AGE_W'(REF_LIMIT))               age <= age + 1'b1;
    end
    assign stale[r] = (age == AGE_W'(REF_LIMIT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       refreshErr <= 1'b0;
    else if (|stale) refreshErr <= 1'b1;
  end

endmodule

// File: rtl/edoStrobeDecoder.sv
module edoStrobeDecoder
  import edoDecPkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int ROW_BITS  = 3,
  parameter int COL_BITS  = 3,
  parameter int REF_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casLoN,
  input  logic              casHiN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic [1:0]        dOutEn,
  output logic [2:0]        cycleKind,
  output logic              refreshErr
);
  laneStrobes_t        stb;
  logic [ROW_BITS-1:0] accRow, touchRow;
  logic [COL_BITS-1:0] accCol;
  logic [ADDR_W-1:0]   refRowCount;

  edoStrobeCtrl #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN({casHiN, casLoN}), .weN(weN),
    .addr(addr), .stb(stb), .accRow(accRow), .accCol(accCol),
    .touchRow(touchRow), .refCount(refRowCount), .kindOut(cycleKind)
  );

  edoWordStore #(.DATA_W(DATA_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) uStore (
    .clk(clk), .rstN(rstN), .stb(stb), .accRow(accRow), .accCol(accCol),
    .dIn(dIn), .oeN(oeN), .dOut(dOut), .dOutEn(dOutEn)
  );

  edoRowAgeWatch #(.ROW_BITS(ROW_BITS), .REF_LIMIT(REF_LIMIT)) uAge (
    .clk(clk), .rstN(rstN), .touch(stb.rowTouch), .touchRow(touchRow),
    .refreshErr(refreshErr)
  );

endmodule

// File: rtl/edoDecoderChecks.sv
module edoDecoderChecks #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rasN,
  input logic              casLoN,
  input logic              casHiN,
  input logic              weN,
  input logic [DATA_W-1:0] dOut,
  input logic [1:0]        dOutEn,
  input logic [2:0]        cycleKind,
  input logic              refreshErr,
  input logic [ADDR_W-1:0] refCount
);
  logic rasP, loP, hiP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasP <= 1'b1;
      loP  <= 1'b1;
      hiP  <= 1'b1;
    end else begin
      rasP <= rasN;
      loP  <= casLoN;
      hiP  <= casHiN;
    end
  end

  assert_idle_kind_R1: assert property (@(posedge clk) disable iff (!rstN)
    rasP |-> (cycleKind == 3'd0));

  assert_rowref_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cycleKind == 3'd4) |-> (dOutEn == 2'b00));

  assert_early_write_hiz_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && !rasP && loP && !casLoN && !weN) |=> !dOutEn[0]);

  assert_release_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rasP && loP) |-> !dOutEn[0]);

  assert_release_hi_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rasP && hiP) |-> !dOutEn[1]);

  assert_rmw_old_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((cycleKind == 3'd3) && ($past(cycleKind) != 3'd3)) |-> $stable(dOut));

  assert_cbr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rasP && !rasN && (!casLoN || !casHiN)) |=> (refCount == $past(refCount) + 1'b1));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    refreshErr |=> refreshErr);

endmodule

bind edoStrobeDecoder edoDecoderChecks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChecks (
  .clk(clk), .rstN(rstN), .rasN(rasN), .casLoN(casLoN), .casHiN(casHiN),
  .weN(weN), .dOut(dOut), .dOutEn(dOutEn), .cycleKind(cycleKind),
  .refreshErr(refreshErr), .refCount(refRowCount)
);

// File: tb/test_edoStrobeDecoder.sv
module test_edoStrobeDecoder;
  localparam int LIMIT = 500;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rasN = 1'b1, casLoN = 1'b1, casHiN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] dIn = '0;
  logic [15:0] dOut;
  logic [1:0]  dOutEn;
  logic [2:0]  cycleKind;
  logic        refreshErr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  edoStrobeDecoder #(.REF_LIMIT(LIMIT)) i_edoStrobeDecoder (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casLoN(casLoN), .casHiN(casHiN),
    .weN(weN), .oeN(oeN), .addr(addr), .dIn(dIn), .dOut(dOut),
    .dOutEn(dOutEn), .cycleKind(cycleKind), .refreshErr(refreshErr)
  );

  typedef struct packed {
    logic        ras, cl, ch, we, oe;
    logic [8:0]  a;
    logic [15:0] d;
    logic [1:0]  en;
    logic        chk;
    logic [15:0] q;
    logic [2:0]  kind;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd1}, // R1 idle
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 9'd5,  16'h0000, 2'b00,1'b0,16'h0000, 3'd4, 4'd2}, // R2 open row 5
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 9'd3,  16'hA5C3, 2'b00,1'b0,16'h0000, 3'd2, 4'd3}, // R3 word write, OE low
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd1},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 9'd5,  16'h0000, 2'b00,1'b0,16'h0000, 3'd4, 4'd2},
    '{1'b0,1'b0,1'b1,1'b1,1'b0, 9'd3,  16'h0000, 2'b01,1'b1,16'h00C3, 3'd1, 4'd4}, // R4 low lane read
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 9'd3,  16'h0000, 2'b01,1'b1,16'h00C3, 3'd1, 4'd5}, // R5 CAS up, held
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd4}, // R4 released
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 9'd5,  16'h0000, 2'b00,1'b0,16'h0000, 3'd4, 4'd2},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd3,  16'h0000, 2'b11,1'b1,16'hA5C3, 3'd1, 4'd4}, // R4 word read
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 9'd3,  16'h0000, 2'b00,1'b1,16'hA5C3, 3'd1, 4'd4}, // R4 OE high
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd3,  16'h0000, 2'b11,1'b1,16'hA5C3, 3'd1, 4'd4},
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 9'd3,  16'h1234, 2'b11,1'b1,16'hA5C3, 3'd3, 4'd6}, // R6 late WE
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd1},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 9'd5,  16'h0000, 2'b00,1'b0,16'h0000, 3'd4, 4'd2},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd3,  16'h0000, 2'b11,1'b1,16'h1234, 3'd1, 4'd6}, // R6 new data stored
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 9'd4,  16'h0000, 2'b11,1'b1,16'h1234, 3'd1, 4'd5}, // R5 new col, hold
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd4,  16'h0000, 2'b11,1'b1,16'h0000, 3'd1, 4'd5}, // R5 reload
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd1},
    '{1'b1,1'b0,1'b0,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd1},
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd5, 4'd7}, // R7 CAS first
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd1},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 9'd2,  16'h0000, 2'b00,1'b0,16'h0000, 3'd4, 4'd2},
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 9'd1,  16'hBEEF, 2'b00,1'b0,16'h0000, 3'd2, 4'd3}, // R3 upper only
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd1},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 9'd2,  16'h0000, 2'b00,1'b0,16'h0000, 3'd4, 4'd2},
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd1,  16'h0000, 2'b11,1'b1,16'hBE00, 3'd1, 4'd3}, // R3 lane split
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd1},
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 9'd13, 16'h0000, 2'b00,1'b0,16'h0000, 3'd4, 4'd8}, // R8 alias of row 5
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 9'd3,  16'h0000, 2'b11,1'b1,16'h1234, 3'd1, 4'd8}, // R8
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 9'd0,  16'h0000, 2'b00,1'b0,16'h0000, 3'd0, 4'd1}
  };

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic pins(input logic r, input logic cl, input logic ch, input logic w,
                      input logic o, input logic [8:0] a, input logic [15:0] d);
    rasN = r; casLoN = cl; casHiN = ch; weN = w; oeN = o; addr = a; dIn = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) pins(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'd0, 16'h0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cbrCycle();
    pins(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 16'h0);
    pins(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 16'h0);
    pins(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'd0, 16'h0);
  endtask

  task automatic rowOnly(input logic [8:0] r);
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, r, 16'h0);
    pins(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'd0, 16'h0);
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    check("R1", "reset dOutEn", {14'd0, dOutEn}, 16'd0);
    check("R1", "reset cycleKind", {13'd0, cycleKind}, 16'd0);
    check("R1", "reset refreshErr", {15'd0, refreshErr}, 16'd0);

    for (int v = 0; v < NV; v++) begin
      pins(VECS[v].ras, VECS[v].cl, VECS[v].ch, VECS[v].we, VECS[v].oe, VECS[v].a, VECS[v].d);
      check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d dOutEn", v), {14'd0, dOutEn}, {14'd0, VECS[v].en});
      check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d cycleKind", v), {13'd0, cycleKind}, {13'd0, VECS[v].kind});
      if (VECS[v].chk)
        check($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d dOut", v), dOut, VECS[v].q);
    end

    // R7: eight strobe-order refreshes must reach every tracked row
    doReset();
    idle(300);
    for (int k = 0; k < 8; k++) cbrCycle();
    idle(250);
    check("R7", "counter sweep keeps rows fresh", {15'd0, refreshErr}, 16'd0);

    // R2: row-only refreshes also renew the age
    doReset();
    idle(300);
    for (int k = 0; k < 8; k++) rowOnly(9'(k));
    idle(250);
    check("R2", "row-only refresh keeps rows fresh", {15'd0, refreshErr}, 16'd0);

    // R9: neglect beyond the limit
    idle(LIMIT + 100);
    check("R9", "age limit exceeded", {15'd0, refreshErr}, 16'd1);

    // R10: sticky until reset
    for (int k = 0; k < 8; k++) rowOnly(9'(k));
    idle(5);
    check("R10", "flag held after refresh", {15'd0, refreshErr}, 16'd1);
    doReset();
    check("R10", "flag cleared by reset", {15'd0, refreshErr}, 16'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule